// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

An eight-pin general-purpose I/O port that sits behind a simple synchronous register bus. Software programs which pins are driven, the levels to drive, and for each pin whether it raises an interrupt. Every pin can be set to trigger on a rising edge, on a falling edge, on a high level or on a low level. A pin may also be given a debounce filter.

Raw pin inputs first pass through a two-flop synchronizer. Edges are found by comparing the filtered level with its value one cycle earlier, and a found edge is latched until software writes a one to that pin's acknowledge bit. A level-sensitive pin reports its live condition instead. A parameter chooses between one combined request line and one request line per pin.

The debounce filter samples on a slow tick made by a prescaler. It takes a new level only after that level has been seen on a fixed number of tick samples in a row. The usual bring-up sequence is:
1. Clear the enable bit.
2. Make the pin an input.
3. Set the trigger and polarity bits.
4. Acknowledge any stale edge.
5. Set the enable bit.

Top module: `gpioIrqPort`

## Requirements
- R1: After reset, pinOe, pinOut and every request output are 0, and the enable register and the masked status read 0.
- R2: The register word index is regAddr: 0 pin data, 1 direction, 2 enable, 3 trigger, 4 polarity, 5 acknowledge, 6 debounce, 7 raw status, 8 masked status. Bit i of each register belongs to pin i. Direction bit 1 drives pinOe bit 1 (output), and pinOut carries the last value written at index 0. Direction reads back as written. Read bits 31..8, and every index above 8, read as 0.
- R3: A read at index 0 returns the pin inputs after a two-flop synchronizer. It does not return the output latch.
- R4: A pin with trigger bit 1 and polarity bit 1 latches a raw status bit on a 0-to-1 input change only. A 1-to-0 change does not set it.
- R5: A pin with trigger bit 1 and polarity bit 0 latches a raw status bit on a 1-to-0 input change only.
- R6: A pin with trigger bit 0 shows its live level in raw status: 1 when the pin is high and the polarity bit is 1, or when the pin is low and the polarity bit is 0. An acknowledge write does not change it.
- R7: Writing 1 to acknowledge bit i clears pin i's latched edge. Acknowledge bits written as 0 leave the latch unchanged.
- R8: Masked status is raw status AND enable. In per-pin mode request line i equals masked bit i. In combined mode the single request line is the OR of the masked bits.
- R9: With debounce bit i set, pin i changes its accepted level only after the new level has been held for DEB_SAMPLES consecutive prescaler ticks. A pulse shorter than that produces no edge.
- R10: An edge that arrives while the pin is disabled stays latched, and the request rises as soon as the enable bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word index |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Combinational read data for regAddr |
| pinIn | input | NUM_PINS | Raw pin input levels |
| pinOut | output | NUM_PINS | Output levels |
| pinOe | output | NUM_PINS | Output enables |
| irqOut | output | NUM_PINS or 1 | Per-pin or combined interrupt requests |

## Verification
The bench walks one pin set through rising, falling and both level modes. It confirms that an edge of the wrong direction is not latched; a design that detected any change would set those bits. Acknowledge writes are applied with zeros in latched positions and ones in level-mode positions. A design that cleared whole words, or that let acknowledge touch level pins, would change the raw status. A short glitch on a debounced pin must leave no edge, and a level held only a few cycles must not yet be accepted, which catches a filter with too short a window. An edge latched while the pin is disabled must raise the request once the pin is enabled; a design that gated latching with the enable bit would lose that edge.

// File: rtl/gpioIrqPkg.sv
package gpioIrqPkg;

  // Register word indices (bus-visible map)
  localparam logic [3:0] RI_DATA = 4'd0;
  localparam logic [3:0] RI_DIR  = 4'd1;
  localparam logic [3:0] RI_IEN  = 4'd2;
  localparam logic [3:0] RI_TRIG = 4'd3;
  localparam logic [3:0] RI_POL  = 4'd4;
  localparam logic [3:0] RI_ACK  = 4'd5;
  localparam logic [3:0] RI_DEB  = 4'd6;
  localparam logic [3:0] RI_RAW  = 4'd7;
  localparam logic [3:0] RI_MASK = 4'd8;
  localparam logic [3:0] RI_NONE = 4'd15;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrData;
    logic       wrDir;
    logic       wrIen;
    logic       wrTrig;
    logic       wrPol;
    logic       wrAck;
    logic       wrDeb;
    logic [3:0] rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpioIrqCtrl.sv
module gpioIrqCtrl
  import gpioIrqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);

  logic       hit;
  logic [3:0] idx;

  // Only the low four index bits select a register; anything above must be zero.
  assign hit = ((regAddr >> 4) == '0) && (regAddr[3:0] <= RI_MASK);
  assign idx = regAddr[3:0];

  always_comb begin
    strobe       = '0;
    strobe.rdSel = hit ? idx : RI_NONE;
    if (regWe && hit) begin
      unique case (idx)
        RI_DATA: strobe.wrData = 1'b1;
        RI_DIR:  strobe.wrDir  = 1'b1;
        RI_IEN:  strobe.wrIen  = 1'b1;
        RI_TRIG: strobe.wrTrig = 1'b1;
        RI_POL:  strobe.wrPol  = 1'b1;
        RI_ACK:  strobe.wrAck  = 1'b1;
        RI_DEB:  strobe.wrDeb  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpioDebounce.sv
module gpioDebounce #(
  parameter int DEB_SAMPLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic din,
  output logic level
);

  localparam int HW = DEB_SAMPLES - 1;

  logic [HW-1:0] hist;
  logic [HW:0]   window;

  // Window = previous tick samples plus the one taken now.
  assign window = {hist, din};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist  <= '0;
      level <= 1'b0;
    end else if (tick) begin
      hist <= window[HW-1:0];
      if (&window)       level <= 1'b1;
      else if (~|window) level <= 1'b0;
    end
  end

endmodule

// File: rtl/gpioIrqDatapath.sv
module gpioIrqDatapath
  import gpioIrqPkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int PRESCALE    = 4,
  parameter int DEB_SAMPLES = 4,
  parameter int SPLIT_IRQ   = 0,
  parameter int IRQ_W       = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [IRQ_W-1:0]    irqOut,
  output logic [DATA_W-1:0]   rdata
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [NUM_PINS-1:0] dataReg, dirReg, ienReg, trigReg, polReg, debReg;
  logic [NUM_PINS-1:0] syncA, syncB, debLvl, lvl, lvlPrev;
  logic [NUM_PINS-1:0] riseHit, fallHit, edgeHit, ackMask, edgeLat;
  logic [NUM_PINS-1:0] levelHit, rawStat, maskStat;
  logic [PS_W-1:0]     psCnt;
  logic                tick;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      ienReg  <= '0;
      trigReg <= '0;
      polReg  <= '0;
      debReg  <= '0;
    end else begin
      if (strobe.wrData) dataReg <= wdata;
      if (strobe.wrDir)  dirReg  <= wdata;
      if (strobe.wrIen)  ienReg  <= wdata;
      if (strobe.wrTrig) trigReg <= wdata;
      if (strobe.wrPol)  polReg  <= wdata;
      if (strobe.wrDeb)  debReg  <= wdata;
    end
  end

  assign pinOut = dataReg;
  assign pinOe  = dirReg;

  // Two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // Prescaler producing the debounce sample tick
  generate
    if (PRESCALE > 1) begin : gPs
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          psCnt <= '0;
        else if (psCnt == PS_W'(PRESCALE - 1)) psCnt <= '0;
        else                                psCnt <= psCnt + 1'b1;
      end
      assign tick = (psCnt == PS_W'(PRESCALE - 1));
    end else begin : gNoPs
      assign psCnt = '0;
      assign tick  = 1'b1;
    end
  endgenerate

  // Per-pin debounce filters
  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : gDeb
      gpioDebounce #(.DEB_SAMPLES(DEB_SAMPLES)) uDeb (
        .clk  (clk),
        .rstN (rstN),
        .tick (tick),
        .din  (syncB[g]),
        .level(debLvl[g])
      );
    end
  endgenerate

  assign lvl = (debReg & debLvl) | (~debReg & syncB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '0;
    else       lvlPrev <= lvl;
  end

  // Edge detection and latching
  assign riseHit = lvl & ~lvlPrev;
  assign fallHit = ~lvl & lvlPrev;
  assign edgeHit = trigReg & ((polReg & riseHit) | (~polReg & fallHit));
  assign ackMask = strobe.wrAck ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLat <= '0;
    else       edgeLat <= (edgeLat & ~ackMask) | edgeHit;
  end

  // Status
  assign levelHit = (polReg & lvl) | (~polReg & ~lvl);
  assign rawStat  = (trigReg & edgeLat) | (~trigReg & levelHit);
  assign maskStat = rawStat & ienReg;

  generate
    if (SPLIT_IRQ != 0) begin : gSplit
      assign irqOut = maskStat;
    end else begin : gComb
      assign irqOut = |maskStat;
    end
  endgenerate

  // Read mux
  always_comb begin
    rdata = '0;
    case (strobe.rdSel)
      RI_DATA: rdata[NUM_PINS-1:0] = syncB;
      RI_DIR:  rdata[NUM_PINS-1:0] = dirReg;
      RI_IEN:  rdata[NUM_PINS-1:0] = ienReg;
      RI_TRIG: rdata[NUM_PINS-1:0] = trigReg;
      RI_POL:  rdata[NUM_PINS-1:0] = polReg;
      RI_DEB:  rdata[NUM_PINS-1:0] = debReg;
      RI_RAW:  rdata[NUM_PINS-1:0] = rawStat;
      RI_MASK: rdata[NUM_PINS-1:0] = maskStat;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpioIrqPort.sv
module gpioIrqPort
  import gpioIrqPkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int PRESCALE    = 4,
  parameter int DEB_SAMPLES = 4,
  parameter int SPLIT_IRQ   = 0
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      regWe,
  input  logic [ADDR_W-1:0]                         regAddr,
  input  logic [DATA_W-1:0]                         regWdata,
  output logic [DATA_W-1:0]                         regRdata,
  input  logic [NUM_PINS-1:0]                       pinIn,
  output logic [NUM_PINS-1:0]                       pinOut,
  output logic [NUM_PINS-1:0]                       pinOe,
  output logic [((SPLIT_IRQ != 0) ? NUM_PINS : 1)-1:0] irqOut
);

  localparam int IRQ_W = (SPLIT_IRQ != 0) ? NUM_PINS : 1;

  ctrlStrobe_t strobe;

  gpioIrqCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  gpioIrqDatapath #(
    .NUM_PINS   (NUM_PINS),
    .DATA_W     (DATA_W),
    .PRESCALE   (PRESCALE),
    .DEB_SAMPLES(DEB_SAMPLES),
    .SPLIT_IRQ  (SPLIT_IRQ),
    .IRQ_W      (IRQ_W)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (regWdata[NUM_PINS-1:0]),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .irqOut(irqOut),
    .rdata (regRdata)
  );

endmodule

// File: rtl/gpioIrqPortChk.sv
module gpioIrqPortChk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IRQ_W    = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [IRQ_W-1:0]    irqOut
);

  logic [NUM_PINS-1:0] ienShadow;
  logic                wasLow;

  // Bus-side model of the enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 ienShadow <= '0;
    else if (regWe && regAddr == ADDR_W'(2))   ienShadow <= regWdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (wasLow) begin
        AST_RESET_IDLE: assert (pinOe == '0 && pinOut == '0 && irqOut == '0); // R1
      end
      wasLow <= 1'b1;
    end else begin
      wasLow <= 1'b0;
    end
  end

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(1)) |=> (pinOe == $past(regWdata[NUM_PINS-1:0]))); // R2

  AST_OUT_TRACKS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0)) |=> (pinOut == $past(regWdata[NUM_PINS-1:0]))); // R2

  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:NUM_PINS] == '0); // R2

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ienShadow == '0) |-> (irqOut == '0)); // R8

endmodule

bind gpioIrqPort gpioIrqPortChk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IRQ_W   ((SPLIT_IRQ != 0) ? NUM_PINS : 1)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqOut  (irqOut)
);

// File: tb/gpioIrqPort_test.sv
`timescale 1ns/1ps
module gpioIrqPort_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [7:0]  pinIn = '0;
  logic [31:0] rdS, rdC;
  logic [7:0]  outS, oeS, outC, oeC, irqS;
  logic [0:0]  irqC;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpioIrqPort #(.SPLIT_IRQ(1)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdS), .pinIn(pinIn), .pinOut(outS), .pinOe(oeS), .irqOut(irqS)
  );

  gpioIrqPort #(.SPLIT_IRQ(0)) uutComb (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rdC), .pinIn(pinIn), .pinOut(outC), .pinOe(oeC), .irqOut(irqC)
  );

  // {doWr, wAddr, wData, pins, chkAddr, expected}
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 4'd0, 8'h00, 8'h00, 4'd7, 8'hFF},  // R6 low-level default, pins low
    {1'b1, 4'd1, 8'hA5, 8'h00, 4'd1, 8'hA5},  // R2 direction readback
    {1'b1, 4'd0, 8'h3C, 8'h00, 4'd0, 8'h00},  // R3 data read is pins, not latch
    {1'b0, 4'd0, 8'h00, 8'h81, 4'd0, 8'h81},  // R3 synchronized pins
    {1'b1, 4'd4, 8'hFF, 8'h81, 4'd7, 8'h81},  // R6 high-level live
    {1'b1, 4'd3, 8'h0F, 8'h81, 4'd7, 8'h80},  // R4 edge mode, no edge yet
    {1'b0, 4'd0, 8'h00, 8'h83, 4'd7, 8'h82},  // R4 rising latched
    {1'b0, 4'd0, 8'h00, 8'h80, 4'd7, 8'h82},  // R4 falling ignored
    {1'b1, 4'd5, 8'hFD, 8'h80, 4'd7, 8'h82},  // R7 zero bit keeps latch, R6 level untouched
    {1'b1, 4'd5, 8'h02, 8'h80, 4'd7, 8'h80},  // R7 one bit clears
    {1'b1, 4'd4, 8'hF0, 8'h80, 4'd7, 8'h80},  // R5 falling polarity
    {1'b0, 4'd0, 8'h00, 8'h84, 4'd7, 8'h80},  // R5 rising ignored
    {1'b0, 4'd0, 8'h00, 8'h80, 4'd7, 8'h84},  // R5 falling latched
    {1'b1, 4'd2, 8'h04, 8'h80, 4'd8, 8'h04}   // R8 masked status
  };
  localparam int VREQ [NV] = '{6, 2, 3, 3, 6, 4, 4, 4, 7, 7, 5, 5, 5, 8};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = {24'h0, d};
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, rdS, {24'h0, exp});
    check({tag, " comb"}, rdC, {24'h0, exp});
  endtask

  initial begin
    // R1 reset state
    waitN(3);
    #1;
    check("R1 pinOe", {24'h0, oeS}, 32'h0);
    check("R1 pinOut", {24'h0, outS}, 32'h0);
    check("R1 irq", {24'h0, irqS} | {31'h0, irqC}, 32'h0);
    rstN = 1'b1;
    waitN(2);
    rdChk("R1 enable", 4'd2, 8'h00);
    rdChk("R1 masked", 4'd8, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) wr(VEC[i][31:28], VEC[i][27:20]);
      pinIn = VEC[i][19:12];
      waitN(4);
      rdChk($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][11:8], VEC[i][7:0]);
    end

    // R2 output pins and unused index
    check("R2 pinOut", {24'h0, outS}, 32'h3C);
    check("R2 pinOe", {24'h0, oeS}, 32'hA5);
    rdChk("R2 unused index", 4'd9, 8'h00);

    // R8 request lines
    check("R8 split irq", {24'h0, irqS}, 32'h04);
    check("R8 comb irq", {31'h0, irqC}, 32'h1);

    // R7 acknowledge drops request
    wr(4'd5, 8'h04);
    waitN(1); #1;
    check("R7 split irq", {24'h0, irqS}, 32'h00);
    check("R7 comb irq", {31'h0, irqC}, 32'h0);

    // R10 edge latched while disabled
    wr(4'd2, 8'h00);
    pinIn = 8'h88; waitN(4);
    pinIn = 8'h80; waitN(4);
    rdChk("R10 latched while off", 4'd7, 8'h88);
    check("R10 no irq while off", {24'h0, irqS}, 32'h00);
    wr(4'd2, 8'h08);
    #1;
    check("R10 irq on enable", {24'h0, irqS}, 32'h08);
    check("R10 comb irq on enable", {31'h0, irqC}, 32'h1);

    // R9 debounce on pin 0, rising edge
    wr(4'd5, 8'hFF);
    wr(4'd4, 8'hF1);
    wr(4'd6, 8'h01);
    waitN(40);
    rdChk("R9 settled", 4'd7, 8'h80);
    pinIn = 8'h81; waitN(3);
    pinIn = 8'h80; waitN(30);
    rdChk("R9 glitch ignored", 4'd7, 8'h80);
    pinIn = 8'h81; waitN(6);
    rdChk("R9 not yet accepted", 4'd7, 8'h80);
    waitN(30);
    rdChk("R9 accepted", 4'd7, 8'h81);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule